// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block turns one transaction request into the ordered list of byte-level commands for an I2C bit engine. The bit engine itself is outside the block. A request is one of three kinds. A probe checks whether a device is present. A read fetches a number of bytes starting at a register address. A write stores a number of bytes starting at a register address. The request carries a 7-bit device address, a register address of up to `ADDR_BYTES` bytes, an address length and a byte count.

Write data comes in on a valid/ready stream. Read data goes out on a valid/ready stream that holds each byte until the consumer takes it. When the transaction ends, the block pulses `done` and presents an error flag and a count of write data bytes that were not acknowledged. Both values stay put until the next request.

The engine takes one command at a time. The command codes are START = 0, STOP = 1, WRITE = 2 and READ = 3. Each command is a one-cycle `eng_cmd_valid` pulse. The engine answers with a one-cycle `eng_done`, which carries the sampled acknowledge (`eng_ack_n`, where 1 means NACK) and, for a READ, the received byte. Request kinds are encoded as probe = 0, read = 1 and write = 2; code 3 behaves as a probe.

Top module: `i2cseq_top`

## Requirements
- R1: A probe issues START, then WRITE of {dev, 0}, then STOP. The register address is never folded into the device address for a probe. `err` is 1 exactly when the address byte was NACKed.
- R2: A read with a nonzero address length begins with START and WRITE of {dev_eff, 0}. If that byte is NACKed, the block issues STOP and completes with `err` = 1.
- R3: The register address is sent as `alen` WRITE commands, most significant byte first. A NACK on any address byte causes an immediate STOP and completion with `err` = 1.
- R4: After the address bytes of a read, the block issues STOP, then START, then WRITE of {dev_eff, 1}. A NACK on that byte gives STOP and `err` = 1.
- R5: A read with `alen` = 0 sends START, then WRITE of {dev_eff, 1} directly. No pointer-setting phase is sent.
- R6: A read issues one READ per byte. `eng_rd_nack` is 0 on every byte except the last, where it is 1. A STOP follows the last byte.
- R7: In a write, a NACK on a data byte does not stop the transfer. Each such NACK adds one to `fail_cnt`. The count is valid with `done`, which comes after the closing STOP, and `err` stays 0. Reads and probes report `fail_cnt` = 0.
- R8: For reads and writes, dev_eff = dev | ((addr >> 8*alen) & OVF_MASK). This lets one device appear as several 256-byte pages.
- R9: `busy` rises the cycle after an accepted `start` and falls the cycle after the one-cycle `done`. A `start` while busy is ignored, and so are request inputs that change mid-transaction. While idle, no command is issued.
- R10: `rd_data` stays stable while `rd_valid` is high and `rd_ready` is low. The next READ, or the closing STOP, is issued only after the byte has been taken.
- R11: `wr_ready` is high only while the block waits for a write data byte. The block waits as long as `wr_valid` is low. The byte sent is the one taken on the stream.
- R12: The engine never has more than one command outstanding. `eng_cmd_valid` lasts one cycle, and the next command waits for `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| op | input | 2 | Request kind: 0 probe, 1 read, 2 write |
| dev | input | 7 | Device address |
| addr | input | 8*ADDR_BYTES | Register address |
| alen | input | clog2(ADDR_BYTES+1) | Number of register address bytes |
| len | input | LEN_W | Number of data bytes |
| wr_valid | input | 1 | Write data valid |
| wr_data | input | 8 | Write data byte |
| wr_ready | output | 1 | Write data accepted this cycle when valid |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data byte |
| rd_ready | input | 1 | Consumer takes the read byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Transaction ended on a device or address NACK |
| fail_cnt | output | LEN_W | NACKed write data bytes |
| eng_cmd_valid | output | 1 | Command strobe to bit engine |
| eng_cmd | output | 2 | Command code |
| eng_tx | output | 8 | Byte for a WRITE command |
| eng_rd_nack | output | 1 | For READ: 1 NACKs the received byte |
| eng_done | input | 1 | Engine finished the current command |
| eng_ack_n | input | 1 | Acknowledge sampled by a WRITE (1 means NACK) |
| eng_rx | input | 8 | Byte received by a READ |

## Verification
Each command shows up on `eng_cmd_valid` one cycle after the `eng_done` of the command before it, and the first START shows up one cycle after `start`. The bench's engine model keeps a queue of the commands it expects and checks each one in the cycle it is strobed. `busy` is checked one cycle after `start`. `done`, `err` and `fail_cnt` are checked in the cycle after the closing STOP's `eng_done`, and `busy` is checked low one cycle after that. A read byte is due on `rd_valid` one cycle after its READ completes. The bench checks it at the handshake it chooses and checks it for stability on every cycle that it withholds `rd_ready`. All sampling happens on the falling clock edge.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [1:0] {
    ECMD_START = 2'd0,
    ECMD_STOP  = 2'd1,
    ECMD_WRITE = 2'd2,
    ECMD_READ  = 2'd3
  } ecmd_t;

  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_SPARE = 2'd3
  } op_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START1,
    ST_DEVW,
    ST_ADDR,
    ST_MSTOP,
    ST_START2,
    ST_DEVR,
    ST_RDATA,
    ST_RHOLD,
    ST_WGET,
    ST_WDATA,
    ST_STOP,
    ST_DONE
  } st_t;

endpackage

// File: rtl/i2cseq_fold.sv
module i2cseq_fold #(
  parameter int          ADDR_BYTES = 4,
  parameter logic [6:0]  OVF_MASK   = 7'h00,
  localparam int         ALEN_W     = $clog2(ADDR_BYTES + 1),
  localparam int         ADDR_W     = 8 * ADDR_BYTES
) (
  input  logic [6:0]        dev,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ALEN_W-1:0] alen,
  input  logic              use_fold,
  output logic [6:0]        dev_eff
);

  generate
    if (OVF_MASK == 7'h00) begin : g_plain
      logic unused_in;
      assign unused_in = use_fold ^ (^addr) ^ (^alen);
      assign dev_eff   = dev;
    end else begin : g_fold
      logic [6:0] hi_bits;
      // Bits just above the last address byte sent.
      always_comb begin
        hi_bits = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
          if (alen == ALEN_W'(i)) hi_bits = addr[8*i +: 7];
        end
      end
      assign dev_eff = use_fold ? (dev | (hi_bits & OVF_MASK)) : dev;
    end
  endgenerate

endmodule

// File: rtl/i2cseq_rdq.sv
module i2cseq_rdq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  output logic       full,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  input  logic       rd_ready
);

  logic       full_q, full_d;
  logic [7:0] data_q;

  always_comb begin
    full_d = full_q;
    if (load)                   full_d = 1'b1;
    else if (full_q && rd_ready) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= din;
  end

  assign full     = full_q;
  assign rd_valid = full_q;
  assign rd_data  = data_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));  // R10

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full_q);  // R10

endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
#(
  parameter int  ADDR_BYTES = 4,
  parameter int  LEN_W      = 8,
  localparam int ALEN_W     = $clog2(ADDR_BYTES + 1),
  localparam int ADDR_W     = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [6:0]        dev_eff,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ALEN_W-1:0] alen,
  input  logic [LEN_W-1:0]  len,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  output logic              wr_ready,
  output logic              rdq_load,
  input  logic              rdq_full,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [LEN_W-1:0]  fail_cnt,
  output logic              eng_cmd_valid,
  output logic [1:0]        eng_cmd,
  output logic [7:0]        eng_tx,
  output logic              eng_rd_nack,
  input  logic              eng_done,
  input  logic              eng_ack_n
);

  st_t               st_q, st_d;
  logic              pend_q, pend_d;
  op_t               op_q;
  logic [6:0]        dev_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ALEN_W-1:0] alen_q;
  logic [ALEN_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [7:0]        wbyte_q, wbyte_d;
  logic              err_q, err_d;
  logic [LEN_W-1:0]  fail_q, fail_d;
  logic              ld_req;
  logic              is_cmd;
  logic              fin;
  logic              is_rd, is_wr;
  logic [7:0]        abyte;

  assign is_rd = (op_q == OP_READ);
  assign is_wr = (op_q == OP_WRITE);

  always_comb begin
    is_cmd = 1'b0;
    case (st_q)
      ST_START1, ST_DEVW, ST_ADDR, ST_MSTOP, ST_START2,
      ST_DEVR, ST_RDATA, ST_WDATA, ST_STOP: is_cmd = 1'b1;
      default:                              is_cmd = 1'b0;
    endcase
  end

  assign fin = is_cmd && pend_q && eng_done;

  // Register address byte selected by the down-counting index.
  always_comb begin
    abyte = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (idx_q == ALEN_W'(i)) abyte = addr_q[8*i +: 8];
    end
  end

  // Next-state logic.
  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    idx_d    = idx_q;
    rem_d    = rem_q;
    wbyte_d  = wbyte_q;
    err_d    = err_q;
    fail_d   = fail_q;
    ld_req   = 1'b0;
    rdq_load = 1'b0;

    if (is_cmd && !pend_q) pend_d = 1'b1;
    if (fin)               pend_d = 1'b0;

    case (st_q)
      ST_IDLE: begin
        if (start) begin
          ld_req = 1'b1;
          rem_d  = len;
          err_d  = 1'b0;
          fail_d = '0;
          st_d   = ST_START1;
        end
      end
      ST_START1: begin
        if (fin) st_d = (is_rd && alen_q == '0) ? ST_DEVR : ST_DEVW;
      end
      ST_DEVW: begin
        if (fin) begin
          if (eng_ack_n) begin
            err_d = 1'b1;
            st_d  = ST_STOP;
          end else if (!is_rd && !is_wr) begin
            st_d = ST_STOP;
          end else if (alen_q != '0) begin
            idx_d = alen_q - 1'b1;
            st_d  = ST_ADDR;
          end else begin
            st_d = (rem_q == '0) ? ST_STOP : ST_WGET;
          end
        end
      end
      ST_ADDR: begin
        if (fin) begin
          if (eng_ack_n) begin
            err_d = 1'b1;
            st_d  = ST_STOP;
          end else if (idx_q == '0) begin
            if (is_rd) st_d = ST_MSTOP;
            else       st_d = (rem_q == '0) ? ST_STOP : ST_WGET;
          end else begin
            idx_d = idx_q - 1'b1;
          end
        end
      end
      ST_MSTOP: begin
        if (fin) st_d = ST_START2;
      end
      ST_START2: begin
        if (fin) st_d = ST_DEVR;
      end
      ST_DEVR: begin
        if (fin) begin
          if (eng_ack_n) begin
            err_d = 1'b1;
            st_d  = ST_STOP;
          end else begin
            st_d = (rem_q == '0) ? ST_STOP : ST_RDATA;
          end
        end
      end
      ST_RDATA: begin
        if (fin) begin
          rdq_load = 1'b1;
          rem_d    = rem_q - 1'b1;
          st_d     = ST_RHOLD;
        end
      end
      ST_RHOLD: begin
        if (!rdq_full) st_d = (rem_q == '0) ? ST_STOP : ST_RDATA;
      end
      ST_WGET: begin
        if (wr_valid) begin
          wbyte_d = wr_data;
          st_d    = ST_WDATA;
        end
      end
      ST_WDATA: begin
        if (fin) begin
          if (eng_ack_n) fail_d = fail_q + 1'b1;
          rem_d = rem_q - 1'b1;
          st_d  = (rem_q == LEN_W'(1)) ? ST_STOP : ST_WGET;
        end
      end
      ST_STOP: begin
        if (fin) st_d = ST_DONE;
      end
      ST_DONE: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Control state registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pend_q  <= 1'b0;
      idx_q   <= '0;
      rem_q   <= '0;
      wbyte_q <= '0;
      err_q   <= 1'b0;
      fail_q  <= '0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      idx_q   <= idx_d;
      rem_q   <= rem_d;
      wbyte_q <= wbyte_d;
      err_q   <= err_d;
      fail_q  <= fail_d;
    end
  end

  // Request capture, enabled only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PROBE;
      dev_q  <= '0;
      addr_q <= '0;
      alen_q <= '0;
    end else if (ld_req) begin
      op_q   <= op_t'(op);
      dev_q  <= dev_eff;
      addr_q <= addr;
      alen_q <= alen;
    end
  end

  // Outputs.
  always_comb begin
    eng_cmd = ECMD_START;
    eng_tx  = '0;
    case (st_q)
      ST_START1, ST_START2: eng_cmd = ECMD_START;
      ST_MSTOP, ST_STOP:    eng_cmd = ECMD_STOP;
      ST_DEVW: begin
        eng_cmd = ECMD_WRITE;
        eng_tx  = {dev_q, 1'b0};
      end
      ST_DEVR: begin
        eng_cmd = ECMD_WRITE;
        eng_tx  = {dev_q, 1'b1};
      end
      ST_ADDR: begin
        eng_cmd = ECMD_WRITE;
        eng_tx  = abyte;
      end
      ST_WDATA: begin
        eng_cmd = ECMD_WRITE;
        eng_tx  = wbyte_q;
      end
      ST_RDATA: eng_cmd = ECMD_READ;
      default:  eng_cmd = ECMD_START;
    endcase
  end

  assign eng_cmd_valid = is_cmd && !pend_q;
  assign eng_rd_nack   = (rem_q == LEN_W'(1));
  assign wr_ready      = (st_q == ST_WGET);
  assign busy          = (st_q != ST_IDLE);
  assign done          = (st_q == ST_DONE);
  assign err           = err_q;
  assign fail_cnt      = fail_q;

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid |=> !eng_cmd_valid);  // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!eng_cmd_valid && !wr_ready));  // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));  // R9

  AST_FAIL_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q != OP_WRITE) |-> (fail_cnt == '0));  // R7

  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(eng_done) && $past(eng_cmd) == ECMD_STOP));  // R7

endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top #(
  parameter int         ADDR_BYTES = 4,
  parameter int         LEN_W      = 8,
  parameter logic [6:0] OVF_MASK   = 7'h00
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [1:0]                         op,
  input  logic [6:0]                         dev,
  input  logic [8*ADDR_BYTES-1:0]            addr,
  input  logic [$clog2(ADDR_BYTES+1)-1:0]    alen,
  input  logic [LEN_W-1:0]                   len,
  input  logic                               wr_valid,
  input  logic [7:0]                         wr_data,
  output logic                               wr_ready,
  output logic                               rd_valid,
  output logic [7:0]                         rd_data,
  input  logic                               rd_ready,
  output logic                               busy,
  output logic                               done,
  output logic                               err,
  output logic [LEN_W-1:0]                   fail_cnt,
  output logic                               eng_cmd_valid,
  output logic [1:0]                         eng_cmd,
  output logic [7:0]                         eng_tx,
  output logic                               eng_rd_nack,
  input  logic                               eng_done,
  input  logic                               eng_ack_n,
  input  logic [7:0]                         eng_rx
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [6:0] dev_eff;
  logic       use_fold;
  logic       rdq_load;
  logic       rdq_full;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign use_fold = (op == 2'd1) || (op == 2'd2);

  i2cseq_fold #(
    .ADDR_BYTES (ADDR_BYTES),
    .OVF_MASK   (OVF_MASK)
  ) u_fold (
    .dev      (dev),
    .addr     (addr),
    .alen     (alen),
    .use_fold (use_fold),
    .dev_eff  (dev_eff)
  );

  i2cseq_ctrl #(
    .ADDR_BYTES (ADDR_BYTES),
    .LEN_W      (LEN_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .start         (start),
    .op            (op),
    .dev_eff       (dev_eff),
    .addr          (addr),
    .alen          (alen),
    .len           (len),
    .wr_valid      (wr_valid),
    .wr_data       (wr_data),
    .wr_ready      (wr_ready),
    .rdq_load      (rdq_load),
    .rdq_full      (rdq_full),
    .busy          (busy),
    .done          (done),
    .err           (err),
    .fail_cnt      (fail_cnt),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_cmd       (eng_cmd),
    .eng_tx        (eng_tx),
    .eng_rd_nack   (eng_rd_nack),
    .eng_done      (eng_done),
    .eng_ack_n     (eng_ack_n)
  );

  i2cseq_rdq u_rdq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (rdq_load),
    .din      (eng_rx),
    .full     (rdq_full),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_ready (rd_ready)
  );

endmodule

// File: tb/i2cseq_tb_top.sv
module i2cseq_tb_top;

  localparam int         AB   = 4;
  localparam int         LW   = 8;
  localparam logic [6:0] MASK = 7'h03;

  typedef struct packed {
    logic [1:0] c;
    logic [7:0] tx;
    logic       rn;
    logic       rnack;
    logic [7:0] rx;
  } ent_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [6:0]    dev = 7'd0;
  logic [31:0]   addr = 32'd0;
  logic [2:0]    alen = 3'd0;
  logic [LW-1:0] len = '0;
  logic          wr_valid = 1'b0;
  logic [7:0]    wr_data = 8'd0;
  logic          wr_ready;
  logic          rd_valid;
  logic [7:0]    rd_data;
  logic          rd_ready = 1'b0;
  logic          busy, done, err;
  logic [LW-1:0] fail_cnt;
  logic          eng_cmd_valid;
  logic [1:0]    eng_cmd;
  logic [7:0]    eng_tx;
  logic          eng_rd_nack;
  logic          eng_done = 1'b0;
  logic          eng_ack_n = 1'b0;
  logic [7:0]    eng_rx = 8'd0;

  ent_t       exq[$];
  logic [7:0] rdexp[$];
  logic [7:0] wrq[$];
  string      cur_req = "R9";
  int         rd_pat = 0;
  int         wr_pat = 0;
  int         cyc = 0;
  int         m_chk = 0, m_fail = 0;
  int         e_chk = 0, e_fail = 0;
  int         r_chk = 0, r_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2cseq_top #(.ADDR_BYTES(AB), .LEN_W(LW), .OVF_MASK(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dev(dev), .addr(addr),
    .alen(alen), .len(len), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .busy(busy), .done(done), .err(err),
    .fail_cnt(fail_cnt), .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd),
    .eng_tx(eng_tx), .eng_rd_nack(eng_rd_nack), .eng_done(eng_done),
    .eng_ack_n(eng_ack_n), .eng_rx(eng_rx));

  // Engine model: pops the expected command, compares it, and answers.
  int   eng_wait = 0;
  logic resp_nack = 1'b0;
  logic [7:0] resp_rx = 8'd0;
  ent_t cur_e;
  always @(negedge clk) begin
    if (eng_done) eng_done <= 1'b0;
    if (eng_wait != 0) begin
      eng_wait = eng_wait - 1;
      if (eng_wait == 0) begin
        eng_done  <= 1'b1;
        eng_ack_n <= resp_nack;
        eng_rx    <= resp_rx;
      end
    end
    if (eng_cmd_valid) begin
      e_chk++;
      if (exq.size() == 0) begin
        e_fail++;
        $display("FAIL %s unexpected command act=%0d exp=none", cur_req, eng_cmd);
        resp_nack = 1'b1;
        resp_rx   = 8'd0;
      end else begin
        cur_e = exq.pop_front();
        if (eng_cmd != cur_e.c ||
            (cur_e.c == 2'd2 && eng_tx != cur_e.tx) ||
            (cur_e.c == 2'd3 && eng_rd_nack != cur_e.rn)) begin
          e_fail++;
          $display("FAIL %s command act=%0d/%02h/%0d exp=%0d/%02h/%0d", cur_req,
                   eng_cmd, eng_tx, eng_rd_nack, cur_e.c, cur_e.tx, cur_e.rn);
        end
        resp_nack = cur_e.rnack;
        resp_rx   = cur_e.rx;
      end
      eng_wait = 2;
    end
  end

  // Read stream consumer with backpressure and hold check (R10).
  logic       hold_prev = 1'b0;
  logic [7:0] data_prev = 8'd0;
  logic       nr;
  logic [7:0] rexp;
  always @(negedge clk) begin
    nr = (rd_pat == 0) || (cyc % rd_pat == 0);
    if (hold_prev) begin
      r_chk++;
      if (!rd_valid || rd_data != data_prev) begin
        r_fail++;
        $display("FAIL R10 hold act=%0d/%02h exp=1/%02h", rd_valid, rd_data, data_prev);
      end
    end
    if (rd_valid && nr) begin
      r_chk++;
      if (rdexp.size() == 0) begin
        r_fail++;
        $display("FAIL %s read byte act=%02h exp=none", cur_req, rd_data);
      end else begin
        rexp = rdexp.pop_front();
        if (rd_data != rexp) begin
          r_fail++;
          $display("FAIL %s read byte act=%02h exp=%02h", cur_req, rd_data, rexp);
        end
      end
    end
    hold_prev = rd_valid && !nr;
    data_prev = rd_data;
    rd_ready <= nr;
  end

  // Write stream producer (R11).
  logic nv;
  always @(negedge clk) begin
    nv = (wrq.size() != 0) && ((wr_pat == 0) || (cyc % wr_pat == 0));
    wr_valid <= nv;
    wr_data  <= nv ? wrq[0] : 8'd0;
    if (nv && wr_ready) void'(wrq.pop_front());
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    m_chk++;
    if (act !== exp) begin
      m_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] c, input logic [7:0] tx, input logic rn,
                      input logic rnack, input logic [7:0] rx);
    ent_t e;
    e.c = c; e.tx = tx; e.rn = rn; e.rnack = rnack; e.rx = rx;
    exq.push_back(e);
  endtask

  // Builds the expected command list from the requirements, runs one request.
  task automatic run_txn(input string req, input int o, input logic [6:0] d,
                         input logic [31:0] a, input int al, input int n,
                         input bit present, input int anack_at, input bit devr_ok,
                         input logic [15:0] wmask, input bit poke);
    logic [63:0] a64;
    logic [6:0]  eff;
    logic [6:0]  hi;
    bit          ok;
    int          eerr, efail, t;
    cur_req = req;
    a64 = 64'(a);
    hi  = 7'(a64 >> (8 * al));
    eff = (o == 0 || o == 3) ? d : (d | (hi & MASK));
    eerr = 0; efail = 0; ok = 1'b1;
    push(2'd0, 8'h00, 1'b0, 1'b0, 8'h00);
    if (o == 0 || o == 3) begin
      push(2'd2, {d, 1'b0}, 1'b0, !present, 8'h00);
      push(2'd1, 8'h00, 1'b0, 1'b0, 8'h00);
      eerr = present ? 0 : 1;
    end else begin
      if (o == 2 || al > 0) begin
        push(2'd2, {eff, 1'b0}, 1'b0, !present, 8'h00);
        if (!present) begin
          push(2'd1, 8'h00, 1'b0, 1'b0, 8'h00);
          eerr = 1; ok = 1'b0;
        end
        for (int k = 0; k < al && ok; k++) begin
          push(2'd2, 8'(a64 >> (8 * (al - 1 - k))), 1'b0, (k == anack_at), 8'h00);
          if (k == anack_at) begin
            push(2'd1, 8'h00, 1'b0, 1'b0, 8'h00);
            eerr = 1; ok = 1'b0;
          end
        end
        if (ok && o == 1) begin
          push(2'd1, 8'h00, 1'b0, 1'b0, 8'h00);
          push(2'd0, 8'h00, 1'b0, 1'b0, 8'h00);
        end
      end
      if (ok && o == 1) begin
        push(2'd2, {eff, 1'b1}, 1'b0, !devr_ok, 8'h00);
        if (!devr_ok) eerr = 1;
        else begin
          for (int i = 0; i < n; i++) begin
            push(2'd3, 8'h00, (i == n - 1), 1'b0, 8'(a[7:0] + 8'(i * 29) + 8'h11));
            rdexp.push_back(8'(a[7:0] + 8'(i * 29) + 8'h11));
          end
        end
        push(2'd1, 8'h00, 1'b0, 1'b0, 8'h00);
      end
      if (ok && o == 2) begin
        for (int i = 0; i < n; i++) begin
          wrq.push_back(8'(8'h3C + 8'(i * 17)));
          push(2'd2, 8'(8'h3C + 8'(i * 17)), 1'b0, wmask[i], 8'h00);
          if (wmask[i]) efail++;
        end
        push(2'd1, 8'h00, 1'b0, 1'b0, 8'h00);
      end
    end

    @(negedge clk);
    start <= 1'b1; op <= 2'(o); dev <= d; addr <= a; alen <= 3'(al); len <= LW'(n);
    @(negedge clk);
    start <= 1'b0;
    chk("R9", "busy after start", 32'(busy), 32'd1);
    if (poke) begin
      repeat (2) @(negedge clk);
      start <= 1'b1; op <= 2'd0; dev <= 7'h7F; addr <= 32'hFFFF_FFFF; alen <= 3'd0;
      @(negedge clk);
      start <= 1'b0;
    end
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      m_chk++; m_fail++;
      $display("FAIL %s done timeout act=0 exp=1", req);
    end else begin
      chk(req, "err", 32'(err), 32'(eerr));
      chk("R7", "fail_cnt", 32'(fail_cnt), 32'(efail));
      chk(req, "commands left", 32'(exq.size()), 32'd0);
      chk("R10", "read bytes left", 32'(rdexp.size()), 32'd0);
      chk("R11", "write bytes left", 32'(wrq.size()), 32'd0);
      @(negedge clk);
      chk("R9", "done pulse width", 32'(done), 32'd0);
      chk("R9", "busy after done", 32'(busy), 32'd0);
    end
    exq.delete(); rdexp.delete(); wrq.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog act=expired exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d",
             m_chk + e_chk + r_chk + 1, m_fail + e_fail + r_fail + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9", "reset busy", 32'(busy), 32'd0);
    chk("R9", "reset done", 32'(done), 32'd0);
    chk("R12", "reset cmd_valid", 32'(eng_cmd_valid), 32'd0);
    chk("R10", "reset rd_valid", 32'(rd_valid), 32'd0);
    chk("R11", "reset wr_ready", 32'(wr_ready), 32'd0);

    // R1: probe, present and absent; register address never folded.
    run_txn("R1", 0, 7'h50, 32'h0000_0300, 1, 0, 1'b1, -1, 1'b1, 16'h0, 1'b0);
    run_txn("R1", 0, 7'h21, 32'h0, 0, 0, 1'b0, -1, 1'b1, 16'h0, 1'b0);
    // R7: write with NACKed data bytes 0 and 2.
    run_txn("R7", 2, 7'h50, 32'h0000_0123, 2, 4, 1'b1, -1, 1'b1, 16'h0005, 1'b0);
    // R6 and R10: read with consumer backpressure.
    rd_pat = 3;
    run_txn("R6", 1, 7'h50, 32'h0000_0045, 2, 4, 1'b1, -1, 1'b1, 16'h0, 1'b0);
    rd_pat = 0;
    // R5: read without pointer phase.
    run_txn("R5", 1, 7'h44, 32'h0000_0000, 0, 2, 1'b1, -1, 1'b1, 16'h0, 1'b0);
    // R2: device absent on pointer phase.
    run_txn("R2", 1, 7'h33, 32'h0000_0010, 2, 3, 1'b0, -1, 1'b1, 16'h0, 1'b0);
    // R3: NACK on second address byte of a write.
    run_txn("R3", 2, 7'h50, 32'h0000_ABCD, 2, 2, 1'b1, 1, 1'b1, 16'h0, 1'b0);
    // R4: NACK on the read-direction address byte.
    run_txn("R4", 1, 7'h50, 32'h0000_0077, 1, 2, 1'b1, -1, 1'b0, 16'h0, 1'b0);
    // R8: page bits folded into the device address.
    run_txn("R8", 1, 7'h50, 32'h0000_0210, 1, 1, 1'b1, -1, 1'b1, 16'h0, 1'b0);
    run_txn("R8", 2, 7'h50, 32'h0000_0110, 1, 1, 1'b1, -1, 1'b1, 16'h0, 1'b0);
    // R9: a second start mid-transaction is ignored.
    run_txn("R9", 2, 7'h50, 32'h0000_0005, 1, 3, 1'b1, -1, 1'b1, 16'h0, 1'b1);
    // R11: slow write data source.
    wr_pat = 5;
    run_txn("R11", 2, 7'h52, 32'h0000_0009, 1, 3, 1'b1, -1, 1'b1, 16'h0002, 1'b0);
    wr_pat = 0;
    // R3: four-byte address, one-byte read.
    run_txn("R3", 1, 7'h50, 32'h1234_5678, 4, 1, 1'b1, -1, 1'b1, 16'h0, 1'b0);
    // R10: long stall on the last and only byte.
    rd_pat = 7;
    run_txn("R10", 1, 7'h50, 32'h0000_0020, 1, 1, 1'b1, -1, 1'b1, 16'h0, 1'b0);
    rd_pat = 0;
    // R12: nothing is issued once idle.
    cur_req = "R12";
    repeat (20) @(negedge clk);
    chk("R12", "idle cmd_valid", 32'(eng_cmd_valid), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d",
             m_chk + e_chk + r_chk, m_fail + e_fail + r_fail);
    $finish;
  end

endmodule